// File: doc/BRIEF.md
# Bus Bridge Quiesce Controller

This controller brings one clock-gated sub-block into service and takes it out again. The sub-block reaches the rest of the chip through two asynchronous bus bridges, one on its master side and one on its slave side. Each bridge is held shut by a stop-request line and answers with an acknowledge line. A bring-up command first runs the sub-block clock long enough for its reset to settle. It then releases the reset, restarts the clock, and opens the master bridge before the slave bridge. A shut-down command closes the bridges in the opposite order, then stops the clock and asserts the reset. A restart command runs a complete shut-down followed by a complete bring-up.

Every bridge handshake must finish within one microsecond. The length of a microsecond comes from a cycles-per-microsecond parameter. When a step fails, the controller undoes the steps it has already completed and then reports failure. A small read-only register view shows each bridge's control and status bits and a fixed identification word.

Top module: `bridge_quiesce_ctrl`

## Requirements
- R1: While reset is held and right after it, the block clock enable is 0, the block reset line is 0 (asserted), both stop-request lines are 1 (bridges shut), and busy, done and fail are all 0.
- R2: A bring-up command makes these changes, one per cycle and in this order: clock on, kept on for exactly WARM = max(32, CYC_PER_US) cycles; clock off; reset released; clock on; master stop-request cleared; then, once the master handshake succeeds, slave stop-request cleared. A one-cycle done pulse follows the slave handshake.
- R3: After each stop-request change, the step succeeds in the first cycle in which that bridge's acknowledge is sampled low. If acknowledge stays high for CYC_PER_US consecutive sampled cycles, the step fails. On a master open that fails this way, the clock turns off exactly CYC_PER_US+1 cycles after the stop-request change.
- R4: If the master open fails, the controller turns the clock off, then asserts reset, then pulses fail. It leaves the slave stop-request at 1 and does not shut the master bridge again.
- R5: If the slave open fails, the controller sets master stop-request to 1 and waits for that handshake. It then turns the clock off, asserts reset, and pulses fail.
- R6: A shut-down command sets slave stop-request, then master stop-request, then turns the clock off, then asserts reset, and ends with a done pulse.
- R7: If shutting the slave bridge fails, the controller pulses fail and changes nothing else. The clock stays on and reset stays released.
- R8: If shutting the master bridge fails, the controller clears slave stop-request again, waits for that handshake and pulses fail. The clock and reset stay untouched.
- R9: A restart command accepted while parent_on is 1 runs the full R6 sequence and then the full R2 sequence, with one done pulse at the end. With parent_on at 0 it is refused: fail pulses in the next cycle and no output changes.
- R10: While busy, any command is refused with a fail pulse in the next cycle, and the running sequence carries on unchanged. When idle, more than one command in the same cycle is also refused with a fail pulse and no output changes.
- R11: reg_rdata shows, one cycle after reg_addr, a 32-bit word. Address 0x00 gives the master bridge and address 0x04 gives the slave bridge, each as bit 0 stop-request, bit 1 acknowledge, bit 2 empty and bit 3 full, with all other bits 0. Address 0x20 gives 0x62726467. Every other address gives 0.
- R12: The block reset line changes only while the clock enable is 0, and a stop-request line falls only while the clock is on and reset is released.
- R13: While the controller is not busy, the clock enable, the reset line and both stop-request lines hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_enable | input | 1 | One-cycle strobe: bring the sub-block up |
| cmd_disable | input | 1 | One-cycle strobe: take the sub-block down |
| cmd_reset | input | 1 | One-cycle strobe: restart (down, then up) |
| parent_on | input | 1 | The enclosing power domain is up |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse: sequence finished well |
| fail | output | 1 | One-cycle pulse: sequence failed or command refused |
| blk_clk_en | output | 1 | Clock enable for the sub-block |
| blk_rst_n | output | 1 | Sub-block reset, low = held in reset |
| mst_stop_req | output | 1 | Master-side bridge stop-request |
| mst_ack | input | 1 | Master-side bridge acknowledge |
| mst_empty | input | 1 | Master-side bridge empty flag |
| mst_full | input | 1 | Master-side bridge full flag |
| slv_stop_req | output | 1 | Slave-side bridge stop-request |
| slv_ack | input | 1 | Slave-side bridge acknowledge |
| slv_empty | input | 1 | Slave-side bridge empty flag |
| slv_full | input | 1 | Slave-side bridge full flag |
| reg_addr | input | 8 | Register view byte address |
| reg_rdata | output | 32 | Register view read data |

## Verification
On every cycle the assertions check several ordering rules. The reset line may only change with the clock stopped. A bridge may only be opened with the clock running and reset released. Outputs stay frozen while idle. A command that arrives during a sequence always draws a fail pulse. A done pulse only ever leaves the block fully up or fully down. The exact order of steps, the warm-up length, the cycle at which a timeout fires and which steps each rollback undoes can only be shown by the bench. Its scenarios hold a bridge acknowledge high at chosen points and compare the recorded order of output changes against the expected order.

// File: rtl/bqc_pkg.sv
package bqc_pkg;

  localparam int          NUM_BRIDGES = 2;
  localparam int          IDX_MST     = 0;
  localparam int          IDX_SLV     = 1;

  localparam int          RD_W        = 32;
  localparam int          ADDR_W      = 8;
  localparam logic [7:0]  ADDR_MST    = 8'h00;
  localparam logic [7:0]  ADDR_SLV    = 8'h04;
  localparam logic [7:0]  ADDR_ID     = 8'h20;
  localparam logic [31:0] ID_WORD     = 32'h6272_6467;

  // bit positions inside a bridge word
  localparam int          B_STOP      = 0;
  localparam int          B_ACK       = 1;
  localparam int          B_EMPTY     = 2;
  localparam int          B_FULL      = 3;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_UP_CLK1,
    ST_UP_WARM,
    ST_UP_REL,
    ST_UP_CLK2,
    ST_UP_OPM,
    ST_UP_WM,
    ST_UP_OPS,
    ST_UP_WS,
    ST_RB_CLM,
    ST_RB_WM,
    ST_FL_CLK,
    ST_FL_RST,
    ST_DN_CLS,
    ST_DN_WS,
    ST_DN_CLM,
    ST_DN_WM,
    ST_RB_OPS,
    ST_RB_WS,
    ST_DN_CLK,
    ST_DN_RST
  } seq_state_t;

endpackage

// File: rtl/bqc_bridge_port.sv
module bqc_bridge_port
  import bqc_pkg::*;
#(
  parameter int WORD_W = RD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              ack_i,
  input  logic              empty_i,
  input  logic              full_i,
  output logic              stop_o,
  output logic [WORD_W-1:0] word_o
);

  logic stop_q;

  always_ff @(posedge clk) begin
    if (rst)          stop_q <= 1'b1;
    else if (close_i) stop_q <= 1'b1;
    else if (open_i)  stop_q <= 1'b0;
  end

  assign stop_o = stop_q;

  always_comb begin
    word_o          = '0;
    word_o[B_STOP]  = stop_q;
    word_o[B_ACK]   = ack_i;
    word_o[B_EMPTY] = empty_i;
    word_o[B_FULL]  = full_i;
  end

endmodule

// File: rtl/bqc_regview.sv
module bqc_regview
  import bqc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = RD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] mst_word_i,
  input  logic [DW-1:0] slv_word_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] sel;

  always_comb begin
    case (addr_i)
      AW'(ADDR_MST): sel = mst_word_i;
      AW'(ADDR_SLV): sel = slv_word_i;
      AW'(ADDR_ID):  sel = DW'(ID_WORD);
      default:       sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= sel;
  end

endmodule

// File: rtl/bqc_seq.sv
module bqc_seq
  import bqc_pkg::*;
#(
  parameter int CYC_PER_US = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_en_i,
  input  logic cmd_dis_i,
  input  logic cmd_rst_i,
  input  logic parent_on_i,
  input  logic ack_m_i,
  input  logic ack_s_i,
  input  logic stop_m_i,
  input  logic stop_s_i,
  output logic open_m_o,
  output logic close_m_o,
  output logic open_s_o,
  output logic close_s_o,
  output logic clk_en_o,
  output logic rst_n_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);

  localparam int WARM    = (CYC_PER_US > 32) ? CYC_PER_US : 32;
  localparam int TMO     = (CYC_PER_US > 0) ? CYC_PER_US : 1;
  localparam int CNT_MAX = (WARM > TMO) ? WARM : TMO;
  localparam int CW      = $clog2(CNT_MAX + 1);

  seq_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, fail_q, clk_q, rstn_q, chain_q;
  logic          any_cmd, multi_cmd, ack_sel, w_ok, w_to;
  logic [1:0]    n_cmd;

  assign n_cmd     = {1'b0, cmd_en_i} + {1'b0, cmd_dis_i} + {1'b0, cmd_rst_i};
  assign any_cmd   = (n_cmd != 2'd0);
  assign multi_cmd = (n_cmd > 2'd1);

  assign ack_sel = (st_q == ST_UP_WM || st_q == ST_RB_WM || st_q == ST_DN_WM)
                 ? ack_m_i : ack_s_i;
  assign w_ok    = !ack_sel;
  assign w_to    = (cnt_q == CW'(TMO - 1));

  assign open_m_o  = (st_q == ST_UP_OPM);
  assign open_s_o  = (st_q == ST_UP_OPS) || (st_q == ST_RB_OPS);
  assign close_m_o = (st_q == ST_RB_CLM) || (st_q == ST_DN_CLM);
  assign close_s_o = (st_q == ST_DN_CLS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      clk_q   <= 1'b0;
      rstn_q  <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      fail_q <= 1'b0;
      if (busy_q && any_cmd) fail_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (any_cmd) begin
            if (multi_cmd || (cmd_rst_i && !parent_on_i)) begin
              fail_q <= 1'b1;
            end else begin
              busy_q  <= 1'b1;
              chain_q <= cmd_rst_i;
              st_q    <= cmd_en_i ? ST_UP_CLK1 : ST_DN_CLS;
            end
          end
        end
        ST_UP_CLK1: begin
          clk_q <= 1'b1;
          cnt_q <= '0;
          st_q  <= ST_UP_WARM;
        end
        ST_UP_WARM: begin
          if (cnt_q == CW'(WARM - 1)) begin
            clk_q <= 1'b0;
            st_q  <= ST_UP_REL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_UP_REL: begin
          rstn_q <= 1'b1;
          st_q   <= ST_UP_CLK2;
        end
        ST_UP_CLK2: begin
          clk_q <= 1'b1;
          st_q  <= ST_UP_OPM;
        end
        ST_UP_OPM: begin
          cnt_q <= '0;
          st_q  <= ST_UP_WM;
        end
        ST_UP_WM: begin
          if (w_ok)      st_q  <= ST_UP_OPS;
          else if (w_to) st_q  <= ST_FL_CLK;
          else           cnt_q <= cnt_q + 1'b1;
        end
        ST_UP_OPS: begin
          cnt_q <= '0;
          st_q  <= ST_UP_WS;
        end
        ST_UP_WS: begin
          if (w_ok) begin
            st_q    <= ST_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            chain_q <= 1'b0;
          end else if (w_to) begin
            st_q <= ST_RB_CLM;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RB_CLM: begin
          cnt_q <= '0;
          st_q  <= ST_RB_WM;
        end
        ST_RB_WM: begin
          if (w_ok || w_to) st_q  <= ST_FL_CLK;
          else              cnt_q <= cnt_q + 1'b1;
        end
        ST_FL_CLK: begin
          clk_q <= 1'b0;
          st_q  <= ST_FL_RST;
        end
        ST_FL_RST: begin
          rstn_q  <= 1'b0;
          st_q    <= ST_IDLE;
          busy_q  <= 1'b0;
          fail_q  <= 1'b1;
          chain_q <= 1'b0;
        end
        ST_DN_CLS: begin
          cnt_q <= '0;
          st_q  <= ST_DN_WS;
        end
        ST_DN_WS: begin
          if (w_ok) begin
            st_q <= ST_DN_CLM;
          end else if (w_to) begin
            st_q    <= ST_IDLE;
            busy_q  <= 1'b0;
            fail_q  <= 1'b1;
            chain_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DN_CLM: begin
          cnt_q <= '0;
          st_q  <= ST_DN_WM;
        end
        ST_DN_WM: begin
          if (w_ok)      st_q  <= ST_DN_CLK;
          else if (w_to) st_q  <= ST_RB_OPS;
          else           cnt_q <= cnt_q + 1'b1;
        end
        ST_RB_OPS: begin
          cnt_q <= '0;
          st_q  <= ST_RB_WS;
        end
        ST_RB_WS: begin
          if (w_ok || w_to) begin
            st_q    <= ST_IDLE;
            busy_q  <= 1'b0;
            fail_q  <= 1'b1;
            chain_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DN_CLK: begin
          clk_q <= 1'b0;
          st_q  <= ST_DN_RST;
        end
        ST_DN_RST: begin
          rstn_q <= 1'b0;
          if (chain_q) begin
            chain_q <= 1'b0;
            st_q    <= ST_UP_CLK1;
          end else begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clk_en_o = clk_q;
  assign rst_n_o  = rstn_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;

  AST_RST_ONLY_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
    !$stable(rstn_q) |-> !clk_q); // R12

  AST_OPEN_NEEDS_CLK: assert property (@(posedge clk) disable iff (rst)
    ($fell(stop_m_i) || $fell(stop_s_i)) |-> (clk_q && rstn_q)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> ($stable(clk_q) && $stable(rstn_q) && $stable(stop_m_i) && $stable(stop_s_i))); // R13

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (cmd_en_i || cmd_dis_i || cmd_rst_i)) |=> fail_q); // R10

  AST_DONE_SETTLED: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ((clk_q && rstn_q && !stop_m_i && !stop_s_i) ||
                (!clk_q && !rstn_q && stop_m_i && stop_s_i))); // R2

endmodule

// File: rtl/bridge_quiesce_ctrl.sv
module bridge_quiesce_ctrl
  import bqc_pkg::*;
#(
  parameter int CYC_PER_US = 200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_enable,
  input  logic        cmd_disable,
  input  logic        cmd_reset,
  input  logic        parent_on,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        blk_clk_en,
  output logic        blk_rst_n,
  output logic        mst_stop_req,
  input  logic        mst_ack,
  input  logic        mst_empty,
  input  logic        mst_full,
  output logic        slv_stop_req,
  input  logic        slv_ack,
  input  logic        slv_empty,
  input  logic        slv_full,
  input  logic [7:0]  reg_addr,
  output logic [31:0] reg_rdata
);

  logic [NUM_BRIDGES-1:0] br_open, br_close, br_ack, br_empty, br_full, br_stop;
  logic [RD_W-1:0]        br_word [NUM_BRIDGES];

  assign br_ack   = {slv_ack, mst_ack};
  assign br_empty = {slv_empty, mst_empty};
  assign br_full  = {slv_full, mst_full};

  generate
    for (genvar g = 0; g < NUM_BRIDGES; g++) begin : g_br
      bqc_bridge_port #(.WORD_W(RD_W)) u_port (
        .clk     (clk),
        .rst     (rst),
        .open_i  (br_open[g]),
        .close_i (br_close[g]),
        .ack_i   (br_ack[g]),
        .empty_i (br_empty[g]),
        .full_i  (br_full[g]),
        .stop_o  (br_stop[g]),
        .word_o  (br_word[g])
      );
    end
  endgenerate

  bqc_seq #(.CYC_PER_US(CYC_PER_US)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .cmd_en_i    (cmd_enable),
    .cmd_dis_i   (cmd_disable),
    .cmd_rst_i   (cmd_reset),
    .parent_on_i (parent_on),
    .ack_m_i     (mst_ack),
    .ack_s_i     (slv_ack),
    .stop_m_i    (br_stop[IDX_MST]),
    .stop_s_i    (br_stop[IDX_SLV]),
    .open_m_o    (br_open[IDX_MST]),
    .close_m_o   (br_close[IDX_MST]),
    .open_s_o    (br_open[IDX_SLV]),
    .close_s_o   (br_close[IDX_SLV]),
    .clk_en_o    (blk_clk_en),
    .rst_n_o     (blk_rst_n),
    .busy_o      (busy),
    .done_o      (done),
    .fail_o      (fail)
  );

  bqc_regview #(.AW(ADDR_W), .DW(RD_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (reg_addr),
    .mst_word_i (br_word[IDX_MST]),
    .slv_word_i (br_word[IDX_SLV]),
    .rdata_o    (reg_rdata)
  );

  assign mst_stop_req = br_stop[IDX_MST];
  assign slv_stop_req = br_stop[IDX_SLV];

endmodule

// File: tb/sim_bridge_quiesce_ctrl.sv
module sim_bridge_quiesce_ctrl;

  localparam int CPU  = 200;
  localparam int WARM = (CPU > 32) ? CPU : 32;
  localparam int TMO  = CPU;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
  logic        parent_on = 1'b1;
  logic        busy, done, fail, blk_clk_en, blk_rst_n;
  logic        mst_stop_req, slv_stop_req, mst_ack, slv_ack;
  logic        mst_empty = 1'b1, mst_full = 1'b0, slv_empty = 1'b0, slv_full = 1'b1;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_rdata;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  bridge_quiesce_ctrl #(.CYC_PER_US(CPU)) u0 (.*);

  // bridge models: ack rises on a stop-request change and drops after ack_len
  int  ack_len = 3;
  bit  m_stuck = 1'b0, s_stuck = 1'b0;
  logic m_last, s_last;
  int  m_cnt, s_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      m_last <= 1'b1; s_last <= 1'b1; m_cnt <= 0; s_cnt <= 0;
    end else begin
      m_last <= mst_stop_req;
      s_last <= slv_stop_req;
      if (mst_stop_req != m_last) m_cnt <= ack_len;
      else if (m_cnt > 0 && !m_stuck) m_cnt <= m_cnt - 1;
      if (slv_stop_req != s_last) s_cnt <= ack_len;
      else if (s_cnt > 0 && !s_stuck) s_cnt <= s_cnt - 1;
    end
  end
  assign mst_ack = (mst_stop_req != m_last) || (m_cnt > 0);
  assign slv_ack = (slv_stop_req != s_last) || (s_cnt > 0);

  // change log: C/c clock on/off, R/r reset released/asserted,
  // M/m master opened/shut, S/s slave opened/shut
  string evlog = "";
  int    t_warm_on, t_warm_off, t_mopen, t_cfirst;
  logic  p_clk, p_rstn, p_ms, p_ss;
  always @(negedge clk) begin
    if (!rst) begin
      if (blk_clk_en !== p_clk) begin
        evlog = {evlog, blk_clk_en ? "C" : "c"};
        if (blk_clk_en && t_warm_on < 0) t_warm_on = cyc;
        if (!blk_clk_en && t_warm_off < 0) t_warm_off = cyc;
        if (!blk_clk_en && t_mopen >= 0 && t_cfirst < 0) t_cfirst = cyc;
      end
      if (blk_rst_n !== p_rstn) evlog = {evlog, blk_rst_n ? "R" : "r"};
      if (mst_stop_req !== p_ms) begin
        evlog = {evlog, mst_stop_req ? "m" : "M"};
        if (!mst_stop_req && t_mopen < 0) t_mopen = cyc;
      end
      if (slv_stop_req !== p_ss) evlog = {evlog, slv_stop_req ? "s" : "S"};
    end
    p_clk = blk_clk_en; p_rstn = blk_rst_n; p_ms = mst_stop_req; p_ss = slv_stop_req;
  end

  bit got_done, got_fail;

  task automatic clear_log();
    evlog = ""; t_warm_on = -1; t_warm_off = -1; t_mopen = -1; t_cfirst = -1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_log(string req, string exp);
    checks++;
    if (evlog != exp) begin
      errors++;
      $display("FAIL %s order: actual \"%s\" expected \"%s\"", req, evlog, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; m_stuck = 0; s_stuck = 0; ack_len = 3; parent_on = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    clear_log();
  endtask

  task automatic strobe(bit e, bit d, bit r);
    @(negedge clk);
    cmd_enable = e; cmd_disable = d; cmd_reset = r;
    @(negedge clk);
    cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
  endtask

  task automatic wait_finish();
    got_done = 0; got_fail = 0;
    for (int i = 0; i < 5000 && !got_done && !got_fail; i++) begin
      @(negedge clk);
      if (done) got_done = 1;
      if (fail) got_fail = 1;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic read_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic bring_up();
    strobe(1, 0, 0); wait_finish(); clear_log();
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "outputs after reset",
        {25'd0, blk_clk_en, blk_rst_n, mst_stop_req, slv_stop_req, busy, done, fail},
        32'b0011000);
  endtask

  task automatic t_regview();
    logic [31:0] d;
    do_reset();
    read_reg(8'h00, d); chk("R11", "master word", d, 32'h5);
    read_reg(8'h04, d); chk("R11", "slave word", d, 32'h9);
    read_reg(8'h20, d); chk("R11", "id word", d, 32'h62726467);
    read_reg(8'h10, d); chk("R11", "unmapped", d, 32'h0);
  endtask

  task automatic t_enable_ok();
    do_reset();
    strobe(1, 0, 0); wait_finish();
    chk_log("R2", "CcRCMS");
    chk("R2", "done/fail", {got_done, got_fail}, 2'b10);
    chk("R2", "warm-up cycles", t_warm_off - t_warm_on, WARM);
    chk("R2", "final state", {blk_clk_en, blk_rst_n, mst_stop_req, slv_stop_req, busy}, 5'b11000);
  endtask

  task automatic t_ack_long();
    do_reset();
    ack_len = TMO - 10;
    strobe(1, 0, 0); wait_finish();
    chk_log("R3", "CcRCMS");
    chk("R3", "long ack still succeeds", {got_done, got_fail}, 2'b10);
  endtask

  task automatic t_mopen_fail();
    logic [31:0] d;
    do_reset();
    m_stuck = 1;
    strobe(1, 0, 0); wait_finish();
    chk_log("R4", "CcRCMcr");
    chk("R4", "fail pulse", {got_done, got_fail}, 2'b01);
    chk("R3", "timeout cycle", t_cfirst - t_mopen, TMO + 1);
    read_reg(8'h00, d); chk("R11", "master word with ack high", d, 32'h6);
  endtask

  task automatic t_sopen_fail();
    do_reset();
    s_stuck = 1;
    strobe(1, 0, 0); wait_finish();
    chk_log("R5", "CcRCMSmcr");
    chk("R5", "fail pulse", {got_done, got_fail}, 2'b01);
  endtask

  task automatic t_disable_ok();
    do_reset(); bring_up();
    strobe(0, 1, 0); wait_finish();
    chk_log("R6", "smcr");
    chk("R6", "done/fail", {got_done, got_fail}, 2'b10);
  endtask

  task automatic t_dis_slave_fail();
    do_reset(); bring_up();
    s_stuck = 1;
    strobe(0, 1, 0); wait_finish();
    chk_log("R7", "s");
    chk("R7", "fail, clock and reset kept", {got_fail, blk_clk_en, blk_rst_n}, 3'b111);
  endtask

  task automatic t_dis_master_fail();
    do_reset(); bring_up();
    m_stuck = 1;
    strobe(0, 1, 0); wait_finish();
    chk_log("R8", "smS");
    chk("R8", "fail, clock and reset kept", {got_fail, blk_clk_en, blk_rst_n}, 3'b111);
  endtask

  task automatic t_restart();
    do_reset(); bring_up();
    strobe(0, 0, 1); wait_finish();
    chk_log("R9", "smcrCcRCMS");
    chk("R9", "single done", {got_done, got_fail}, 2'b10);
    clear_log();
    parent_on = 1'b0;
    strobe(0, 0, 1);
    chk("R9", "refused without parent", {fail, busy}, 2'b10);
    repeat (5) @(negedge clk);
    chk_log("R9", "");
  endtask

  task automatic t_busy_refuse();
    do_reset();
    strobe(1, 0, 0);
    repeat (10) @(negedge clk);
    strobe(0, 1, 0);
    chk("R10", "refused while busy", {fail, busy}, 2'b11);
    wait_finish();
    chk_log("R10", "CcRCMS");
    chk("R10", "sequence unaffected", {got_done, got_fail}, 2'b10);
  endtask

  task automatic t_multi_cmd();
    do_reset();
    strobe(1, 1, 0);
    chk("R10", "two strobes refused", {fail, busy}, 2'b10);
    repeat (5) @(negedge clk);
    chk_log("R10", "");
  endtask

  initial begin
    clear_log();
    t_reset_state();
    t_regview();
    t_enable_ok();
    t_ack_long();
    t_mopen_fail();
    t_sopen_fail();
    t_disable_ok();
    t_dis_slave_fail();
    t_dis_master_fail();
    t_restart();
    t_busy_refuse();
    t_multi_cmd();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule